// File: doc/BRIEF.md
# Bit-Serial Accumulator

This block keeps a running sum in an n-bit register and adds an operand to it one bit per clock. It uses a single one-bit full adder and a carry flip-flop instead of a carry-propagate adder. The operand is written as a parallel word into its own shift register. A start command then runs exactly n shift cycles. In each cycle the low bits of the operand and of the sum meet in the adder. The sum bit enters the top of the accumulator, and the carry out is held for the next bit position.

The host clears the sum when needed, loads an operand, and starts an add. It then waits for the one-cycle done pulse. The operand register rotates rather than drains, so it holds its original value when an add ends. A further start adds the same operand again. The carry left by the final bit is reported as an unsigned carry flag. The width must be 2 or more.

Top module: `serial_accum`

## Requirements
- R1: After reset, `acc_o` is 0, `carry_o` is 0, `busy_o` is 0 and `done_o` is 0.
- R2: While idle, `clr_i` high at a clock edge sets `acc_o` and `carry_o` to 0 from the next cycle on.
- R3: While idle, `load_i` high at a clock edge stores `x_i` as the operand that the next add uses.
- R4: While idle, `start_i` high at a clock edge raises `busy_o` in the next cycle. `busy_o` then stays high for exactly WIDTH cycles.
- R5: When an add completes, `acc_o` equals (Z + X) mod 2^WIDTH, where Z is the sum before the add and X is the operand. `carry_o` equals bit WIDTH of Z + X.
- R6: The carry flip-flop is cleared when each add begins. A carry left by an earlier add never enters the next result.
- R7: `done_o` is high for exactly one cycle, the first cycle after the last shift, and `busy_o` is low in that cycle.
- R8: Successive adds accumulate onto the sum without a clear. The operand register keeps its value across an add, so a repeated start adds the same operand again.
- R9: While `busy_o` is high, `clr_i`, `load_i` and `start_i` have no effect. The add finishes on time with the original operand and sum, and the operand is unchanged afterwards.
- R10: While idle and with `clr_i` low, `acc_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clear sum and carry (idle only) |
| load_i | input | 1 | Load operand from `x_i` (idle only) |
| x_i | input | WIDTH | Parallel operand |
| start_i | input | 1 | Begin an n-cycle serial add (idle only) |
| busy_o | output | 1 | High while shifting |
| done_o | output | 1 | One-cycle pulse after the last shift |
| acc_o | output | WIDTH | Parallel value of the sum register |
| carry_o | output | 1 | Carry flip-flop, final carry after an add |

## Verification
The bench builds two copies of the block, one with WIDTH 8 and one with WIDTH 3. The 8-bit copy runs directed cases: carries that ripple across every bit, wrap to zero, carry leakage between adds, repeated starts, and commands issued while the add is running. The 3-bit copy is small enough to try every pair of starting sum and operand. This brings every carry pattern and the shortest counter range within reach.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

  // One-bit full adder: returns {carry_out, sum}
  function automatic logic [1:0] fa_bit(input logic a, input logic b, input logic cin);
    logic s;
    logic co;
    s  = a ^ b ^ cin;
    co = (a & b) | (a & cin) | (b & cin);
    return {co, s};
  endfunction

endpackage

// File: rtl/sacc_shreg.sv
module sacc_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  input  logic             shift,
  input  logic             sin,
  output logic [WIDTH-1:0] q
);

  // Right shift: the bit at index 0 leaves, sin enters at the top
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clr)   q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {sin, q[WIDTH-1:1]};
  end

endmodule

// File: rtl/sacc_bitadd.sv
module sacc_bitadd (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic a,
  input  logic b,
  output logic sum,
  output logic carry_q
);
  import sacc_pkg::*;

  logic [1:0] res;
  logic       cout;

  always_comb begin
    res  = fa_bit(a, b, carry_q);
    sum  = res[0];
    cout = res[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   carry_q <= 1'b0;
    else if (clr) carry_q <= 1'b0;
    else if (en)  carry_q <= cout;
  end

  // R6: a clear (start of an add or a clear command) leaves no carry behind
  assert_carry_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (carry_q == 1'b0));

endmodule

// File: rtl/sacc_ctrl.sv
module sacc_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic load_i,
  input  logic start_i,
  output logic clr_acc,
  output logic load_x,
  output logic begin_add,
  output logic shift_en,
  output logic last_shift,
  output logic busy_o,
  output logic done_o
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(WIDTH);

  logic [CW-1:0] cnt;
  logic          idle;

  assign idle       = (cnt == '0);
  assign begin_add  = start_i & idle;
  assign clr_acc    = clr_i & idle;
  assign load_x     = load_i & idle;
  assign shift_en   = ~idle;
  assign last_shift = (cnt == CW'(1));
  assign busy_o     = shift_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (begin_add) cnt <= CNT_FULL;
    else if (shift_en)  cnt <= cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_o <= 1'b0;
    else        done_o <= last_shift;
  end

  // R4: a start taken while idle loads the full shift count
  assert_start_loads_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && cnt == CNT_FULL));

  // R7: done is a single-cycle pulse
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: done follows the shift phase and the block is idle again
  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R9: a start while busy does not reload the counter
  assert_start_ignored_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_shift) |=> (cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/serial_accum.sv
module serial_accum #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] x_i,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] acc_o,
  output logic             carry_o
);

  logic             clr_acc;
  logic             load_x;
  logic             begin_add;
  logic             shift_en;
  logic             last_shift;
  logic             sum_bit;
  logic             carry_q;
  logic             carry_clr;
  logic [WIDTH-1:0] x_q;
  logic [WIDTH-1:0] z_q;

  sacc_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .load_i     (load_i),
    .start_i    (start_i),
    .clr_acc    (clr_acc),
    .load_x     (load_x),
    .begin_add  (begin_add),
    .shift_en   (shift_en),
    .last_shift (last_shift),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  // Operand register rotates so its value survives the add
  sacc_shreg #(.WIDTH(WIDTH)) u_xreg (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (1'b0),
    .load  (load_x),
    .din   (x_i),
    .shift (shift_en),
    .sin   (x_q[0]),
    .q     (x_q)
  );

  // Sum register takes each new sum bit at its top end
  sacc_shreg #(.WIDTH(WIDTH)) u_zreg (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_acc),
    .load  (1'b0),
    .din   ('0),
    .shift (shift_en),
    .sin   (sum_bit),
    .q     (z_q)
  );

  assign carry_clr = clr_acc | begin_add;

  sacc_bitadd u_add (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (carry_clr),
    .en      (shift_en),
    .a       (x_q[0]),
    .b       (z_q[0]),
    .sum     (sum_bit),
    .carry_q (carry_q)
  );

  assign acc_o   = z_q;
  assign carry_o = carry_q;

  // R2: a clear while idle zeroes sum and carry
  assert_clear_zeroes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !busy_o) |=> (acc_o == '0 && carry_o == 1'b0));

  // R10: sum holds while idle without a clear
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !clr_i) |=> $stable(acc_o));

  // R9: while busy the operand only rotates, whatever load_i does
  assert_operand_rotates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (x_q == {$past(x_q[0]), $past(x_q[WIDTH-1:1])}));

  // R3: a load while idle captures the parallel word
  assert_load_captures_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !busy_o) |=> (x_q == $past(x_i)));

endmodule

// File: tb/serial_accum_bench.sv
module serial_accum_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W8 = 8;
  localparam int W3 = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          clr8 = 0, ld8 = 0, st8 = 0;
  logic [W8-1:0] x8 = '0;
  logic          busy8, done8, car8;
  logic [W8-1:0] acc8;

  logic          clr3 = 0, ld3 = 0, st3 = 0;
  logic [W3-1:0] x3 = '0;
  logic          busy3, done3, car3;
  logic [W3-1:0] acc3;

  serial_accum #(.WIDTH(W8)) u_serial_accum (
    .clk(clk), .rst_n(rst_n), .clr_i(clr8), .load_i(ld8), .x_i(x8),
    .start_i(st8), .busy_o(busy8), .done_o(done8), .acc_o(acc8), .carry_o(car8)
  );

  serial_accum #(.WIDTH(W3)) u_serial_accum_w3 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr3), .load_i(ld3), .x_i(x3),
    .start_i(st3), .busy_o(busy3), .done_o(done3), .acc_o(acc3), .carry_o(car3)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model per instance (0 = 8-bit, 1 = 3-bit)
  int zm [2];
  int xm [2];
  int cm [2];

  function automatic int wid(input int sel);
    return (sel == 1) ? W3 : W8;
  endfunction

  function automatic int get_acc(input int sel);
    return (sel == 1) ? int'(acc3) : int'(acc8);
  endfunction
  function automatic bit get_busy(input int sel);
    return (sel == 1) ? busy3 : busy8;
  endfunction
  function automatic bit get_done(input int sel);
    return (sel == 1) ? done3 : done8;
  endfunction
  function automatic bit get_car(input int sel);
    return (sel == 1) ? car3 : car8;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int sel, input bit c, input bit l, input bit s, input int x);
    if (sel == 1) begin clr3 = c; ld3 = l; st3 = s; x3 = W3'(x); end
    else          begin clr8 = c; ld8 = l; st8 = s; x8 = W8'(x); end
  endtask

  // Holds a command for one clock edge, returns at the following negedge
  task automatic pulse(input int sel, input bit c, input bit l, input bit s, input int x);
    drive(sel, c, l, s, x);
    @(negedge clk);
    drive(sel, 1'b0, 1'b0, 1'b0, 0);
  endtask

  task automatic do_clear(input int sel);
    pulse(sel, 1, 0, 0, 0);
    zm[sel] = 0; cm[sel] = 0;
    chk(get_acc(sel) == 0 && get_car(sel) == 0, "R2", get_acc(sel), 0);
  endtask

  task automatic do_load(input int sel, input int x);
    pulse(sel, 0, 1, 0, x);
    xm[sel] = x;
  endtask

  // Runs one add; with disturb, clear/load/start are pulsed mid-add (R9)
  task automatic do_add(input int sel, input bit disturb, input string req);
    int w = wid(sel);
    int busy_cnt;
    int full;
    pulse(sel, 0, 0, 1, 0);
    busy_cnt = get_busy(sel) ? 1 : 0;
    if (disturb) begin
      pulse(sel, 1, 1, 1, ~xm[sel]);
      if (get_busy(sel)) busy_cnt++;
    end
    for (int i = (disturb ? 1 : 0); i < w; i++) begin
      @(negedge clk);
      if (get_busy(sel)) busy_cnt++;
    end
    full = zm[sel] + xm[sel];
    zm[sel] = full % (1 << w);
    cm[sel] = (full >> w) & 1;
    chk(busy_cnt == w, "R4", busy_cnt, w);
    chk(get_done(sel) == 1 && get_busy(sel) == 0, "R7", get_done(sel), 1);
    chk(get_acc(sel) == zm[sel], req, get_acc(sel), zm[sel]);
    chk(get_car(sel) == cm[sel], req, get_car(sel), cm[sel]);
    @(negedge clk);
    chk(get_done(sel) == 0, "R7", get_done(sel), 0);
  endtask

  task automatic t_reset();
    chk(acc8 == 0 && car8 == 0, "R1", acc8, 0);
    chk(busy8 == 0 && done8 == 0, "R1", busy8, 0);
    chk(acc3 == 0 && car3 == 0 && busy3 == 0, "R1", acc3, 0);
  endtask

  task automatic t_basic();
    do_clear(0);
    do_load(0, 8'h5A);
    do_add(0, 0, "R3");
    do_load(0, 8'hC3);
    do_add(0, 0, "R5");
    do_load(0, 8'h01);
    do_add(0, 0, "R6");
  endtask

  task automatic t_repeat();
    do_add(0, 0, "R8");
    do_add(0, 0, "R8");
  endtask

  task automatic t_busy_ignore();
    do_add(0, 1, "R9");
    do_add(0, 0, "R9");
  endtask

  task automatic t_idle_hold();
    int held = acc8;
    repeat (5) @(negedge clk);
    chk(acc8 == held, "R10", acc8, held);
  endtask

  task automatic t_wrap();
    do_clear(0);
    do_load(0, 8'hFF);
    do_add(0, 0, "R5");
    do_load(0, 8'h01);
    do_add(0, 0, "R5");
    do_load(0, 8'hFF);
    do_add(0, 0, "R5");
    do_add(0, 0, "R6");
  endtask

  task automatic t_exhaustive3();
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        do_clear(1);
        do_load(1, a);
        do_add(1, 0, "R5");
        do_load(1, b);
        do_add(1, 0, "R5");
      end
    end
  endtask

  initial begin
    zm[0] = 0; zm[1] = 0; xm[0] = 0; xm[1] = 0; cm[0] = 0; cm[1] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_repeat();
    t_busy_ignore();
    t_idle_hold();
    t_wrap();
    t_exhaustive3();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule